// File: doc/BRIEF.md
# Local Target Transfer Handshake

This block sits between the bus-side decode of a target access and a simple local-side data port. When the decoder reports a valid access, the block latches the command, the address and the region that was hit. It opens a local session and then moves data words one at a time through a ready/strobe pair. A read takes each word from the local side and hands it to the bus side. A write hands each bus word to the local side.

Regions marked as 64-bit get a second strobe that covers the upper half of the data path. Narrow regions use only the lower half. Special-cycle commands reach the local side without any region selected. Reserved commands never reach the local side, and the block answers each bus offer itself with an all-zero word.

The bus side offers a word with `bus_dv_i` and learns that the word was consumed through `bus_take_o`. The local side signals readiness with `loc_rdy_n_i`. A ready level seen in one cycle commits the local side to one transfer, which is strobed in the following cycle.

Top module: `lth_target`

## Requirements
- R1: After synchronous reset, `loc_acc_n_o`, `xfer_lo_n_o` and `xfer_hi_n_o` are 1, `bus_rvalid_o` is 0, and all hit outputs are 0.
- R2: One cycle after `acc_n_i` first goes low, `loc_acc_n_o` goes low, and `loc_cmd_o`, `loc_addr_o` and the hit outputs show the values presented at that start cycle. At most one hit output is set.
- R3: For command code 0001 (special cycle), the local session opens with every hit output at 0, and transfers use the low strobe only.
- R4: The low strobe `xfer_lo_n_o` is low in a cycle only if `loc_rdy_n_i` was low in the previous cycle. On a read (command bit 0 = 0, code not reserved, `loc_rd_nwr_o`=1), the word on `loc_rdata_i` during a strobe cycle appears on `bus_rdata_o` with `bus_rvalid_o`=1 in the next cycle, and words arrive in order.
- R5: While the access, the bus offer and local ready all stay active, strobes follow on consecutive cycles. A cycle with ready high produces no strobe in the next cycle.
- R6: On a write (command bit 0 = 1), each consumed bus word appears on `loc_wdata_o`, with its byte enables on `loc_be_o`, during its strobe cycle, in order.
- R7: For a region whose bit in `WIDE_MASK` is 0, and for capability or ROM hits, `xfer_hi_n_o` never goes low. The upper 32 bits of `loc_wdata_o` and `bus_rdata_o` and the upper 4 bits of `loc_be_o` are 0.
- R8: For a region whose bit in `WIDE_MASK` is 1, `xfer_hi_n_o` goes low in exactly the cycles where `xfer_lo_n_o` goes low, and all 64 data bits pass.
- R9: One cycle after `acc_n_i` returns high, `loc_acc_n_o` is 1 and every hit output is 0.
- R10: For codes 0100, 0101, 1000 and 1001, `loc_acc_n_o` stays 1 and no strobe occurs. Each bus offer is consumed and answered in the next cycle with `bus_rvalid_o`=1 and `bus_rdata_o`=0.
- R11: No transfer strobe is low while `loc_acc_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_n_i | input | 1 | Decoded access valid, active low |
| hit_i | input | NREG | One-hot region hit, valid at access start |
| cap_hit_i | input | 1 | Capability-list hit |
| rom_hit_i | input | 1 | Expansion ROM hit |
| cmd_i | input | 4 | Bus command code |
| addr_i | input | AW | Access address |
| bus_dv_i | input | 1 | Bus side offers a word (write data or read slot) |
| wdata_i | input | DW | Bus write data |
| wbe_i | input | DW/8 | Bus byte enables, active high |
| bus_take_o | output | 1 | Offered word is consumed at the next clock edge |
| bus_rdata_o | output | DW | Read data returned to the bus side |
| bus_rvalid_o | output | 1 | `bus_rdata_o` holds a returned word |
| loc_acc_n_o | output | 1 | Local session open, active low |
| loc_hit_o | output | NREG | Latched region hit |
| loc_cap_hit_o | output | 1 | Latched capability hit |
| loc_rom_hit_o | output | 1 | Latched ROM hit |
| loc_cmd_o | output | 4 | Latched command |
| loc_addr_o | output | AW | Latched address |
| loc_rd_nwr_o | output | 1 | 1 for read, 0 for write or special cycle |
| loc_rdy_n_i | input | 1 | Local ready, active low |
| loc_rdata_i | input | DW | Local read data |
| loc_wdata_o | output | DW | Write data to the local side |
| loc_be_o | output | DW/8 | Byte enables to the local side |
| xfer_lo_n_o | output | 1 | Lower-half transfer strobe, active low |
| xfer_hi_n_o | output | 1 | Upper-half transfer strobe, active low |

## Verification
The bench builds the block with six regions, a 64-bit address, a 64-bit data path and `WIDE_MASK` = 6'b100100. Regions 2 and 5 are therefore wide and the rest are narrow. With these settings, one run covers paired strobes, low-half-only transfers with zeroed upper lanes, and capture of a full 64-bit address. Read and write bursts run with and without local waits, against special-cycle and reserved command codes.

// File: rtl/lth_pkg.sv
package lth_pkg;

  typedef enum logic [1:0] {
    K_READ    = 2'd0,
    K_WRITE   = 2'd1,
    K_SPECIAL = 2'd2,
    K_RSVD    = 2'd3
  } cmd_kind_e;

  // Command class: special broadcast, ignored codes, else bit 0 picks direction.
  function automatic cmd_kind_e classify(input logic [3:0] code);
    case (code)
      4'b0001:                            return K_SPECIAL;
      4'b0100, 4'b0101, 4'b1000, 4'b1001: return K_RSVD;
      default:                            return code[0] ? K_WRITE : K_READ;
    endcase
  endfunction

  // A hit vector selects a wide region when it overlaps the wide mask.
  function automatic logic region_is_wide(input logic [31:0] hits,
                                          input logic [31:0] mask);
    return |(hits & mask);
  endfunction

endpackage

// File: rtl/lth_session.sv
module lth_session
  import lth_pkg::*;
#(
  parameter int          NREG      = 6,
  parameter int          AW        = 32,
  parameter logic [31:0] WIDE_MASK = 32'h0000_0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_n_i,
  input  logic [NREG-1:0] hit_i,
  input  logic            cap_hit_i,
  input  logic            rom_hit_i,
  input  logic [3:0]      cmd_i,
  input  logic [AW-1:0]   addr_i,
  output logic            open_o,
  output cmd_kind_e       kind_o,
  output logic            wide_o,
  output logic            loc_acc_n_o,
  output logic [NREG-1:0] loc_hit_o,
  output logic            loc_cap_hit_o,
  output logic            loc_rom_hit_o,
  output logic [3:0]      loc_cmd_o,
  output logic [AW-1:0]   loc_addr_o,
  output logic            loc_rd_nwr_o
);

  logic      open_q;
  cmd_kind_e kind_q;
  logic      wide_q;

  cmd_kind_e kind_now_w;
  logic      start_w;
  logic      no_region_w;

  assign kind_now_w  = classify(cmd_i);
  assign start_w     = !acc_n_i && !open_q;
  assign no_region_w = (kind_now_w == K_SPECIAL) || (kind_now_w == K_RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q        <= 1'b0;
      kind_q        <= K_READ;
      wide_q        <= 1'b0;
      loc_acc_n_o   <= 1'b1;
      loc_hit_o     <= '0;
      loc_cap_hit_o <= 1'b0;
      loc_rom_hit_o <= 1'b0;
      loc_cmd_o     <= '0;
      loc_addr_o    <= '0;
      loc_rd_nwr_o  <= 1'b1;
    end else if (start_w) begin
      open_q        <= 1'b1;
      kind_q        <= kind_now_w;
      wide_q        <= !no_region_w && region_is_wide(32'(hit_i), WIDE_MASK);
      loc_acc_n_o   <= (kind_now_w == K_RSVD);
      loc_hit_o     <= no_region_w ? '0 : hit_i;
      loc_cap_hit_o <= !no_region_w && cap_hit_i;
      loc_rom_hit_o <= !no_region_w && rom_hit_i;
      loc_cmd_o     <= cmd_i;
      loc_addr_o    <= addr_i;
      loc_rd_nwr_o  <= (kind_now_w == K_READ);
    end else if (acc_n_i) begin
      open_q        <= 1'b0;
      wide_q        <= 1'b0;
      loc_acc_n_o   <= 1'b1;
      loc_hit_o     <= '0;
      loc_cap_hit_o <= 1'b0;
      loc_rom_hit_o <= 1'b0;
    end
  end

  assign open_o = open_q;
  assign kind_o = kind_q;
  assign wide_o = wide_q;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o})); // R2
  AST_SPECIAL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_acc_n_o && loc_cmd_o == 4'b0001) |-> ({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o} == '0)); // R3
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_acc_n_o) |-> ({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o} == '0)); // R9
  AST_RSVD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && kind_q == K_RSVD) |-> loc_acc_n_o); // R10

endmodule

// File: rtl/lth_xfer.sv
module lth_xfer
  import lth_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            open_i,
  input  cmd_kind_e       kind_i,
  input  logic            wide_i,
  input  logic            acc_n_i,
  input  logic            bus_dv_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] wbe_i,
  input  logic            loc_rdy_n_i,
  input  logic [DW-1:0]   loc_rdata_i,
  output logic            bus_take_o,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            bus_rvalid_o,
  output logic [DW-1:0]   loc_wdata_o,
  output logic [DW/8-1:0] loc_be_o,
  output logic            xfer_lo_n_o,
  output logic            xfer_hi_n_o
);

  localparam int HALF  = DW / 2;
  localparam int BEW   = DW / 8;
  localparam int HBEW  = BEW / 2;

  function automatic logic [DW-1:0] low_data(input logic [DW-1:0] d);
    return {{HALF{1'b0}}, d[HALF-1:0]};
  endfunction

  function automatic logic [BEW-1:0] low_be(input logic [BEW-1:0] b);
    return {{HBEW{1'b0}}, b[HBEW-1:0]};
  endfunction

  logic data_sess_w;
  logic go_w;
  logic rsv_take_w;
  logic rd_phase_w;

  assign data_sess_w = open_i && (kind_i != K_RSVD);
  assign go_w        = data_sess_w && !acc_n_i && bus_dv_i && !loc_rdy_n_i;
  assign rsv_take_w  = open_i && (kind_i == K_RSVD) && !acc_n_i && bus_dv_i;
  assign rd_phase_w  = !xfer_lo_n_o && (kind_i == K_READ);
  assign bus_take_o  = go_w || rsv_take_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_lo_n_o  <= 1'b1;
      xfer_hi_n_o  <= 1'b1;
      loc_wdata_o  <= '0;
      loc_be_o     <= '0;
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      xfer_lo_n_o  <= !go_w;
      xfer_hi_n_o  <= !(go_w && wide_i);
      if (go_w) begin
        loc_wdata_o <= wide_i ? wdata_i : low_data(wdata_i);
        loc_be_o    <= wide_i ? wbe_i : low_be(wbe_i);
      end
      bus_rvalid_o <= rsv_take_w || rd_phase_w;
      if (rsv_take_w)
        bus_rdata_o <= '0;
      else if (rd_phase_w)
        bus_rdata_o <= !xfer_hi_n_o ? loc_rdata_i : low_data(loc_rdata_i);
    end
  end

  AST_XFER_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_lo_n_o |-> ($past(loc_rdy_n_i) == 1'b0)); // R4
  AST_HI_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_hi_n_o |-> !xfer_lo_n_o); // R8
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_lo_n_o && xfer_hi_n_o) |-> (loc_be_o[BEW-1:HBEW] == '0 && loc_wdata_o[DW-1:HALF] == '0)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rsv_take_w) |-> (bus_rvalid_o && bus_rdata_o == '0)); // R10

endmodule

// File: rtl/lth_target.sv
module lth_target
  import lth_pkg::*;
#(
  parameter int          NREG      = 6,
  parameter int          AW        = 32,
  parameter int          DW        = 64,
  parameter logic [31:0] WIDE_MASK = 32'h0000_0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_n_i,
  input  logic [NREG-1:0] hit_i,
  input  logic            cap_hit_i,
  input  logic            rom_hit_i,
  input  logic [3:0]      cmd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            bus_dv_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] wbe_i,
  output logic            bus_take_o,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            bus_rvalid_o,
  output logic            loc_acc_n_o,
  output logic [NREG-1:0] loc_hit_o,
  output logic            loc_cap_hit_o,
  output logic            loc_rom_hit_o,
  output logic [3:0]      loc_cmd_o,
  output logic [AW-1:0]   loc_addr_o,
  output logic            loc_rd_nwr_o,
  input  logic            loc_rdy_n_i,
  input  logic [DW-1:0]   loc_rdata_i,
  output logic [DW-1:0]   loc_wdata_o,
  output logic [DW/8-1:0] loc_be_o,
  output logic            xfer_lo_n_o,
  output logic            xfer_hi_n_o
);

  logic      open_w;
  cmd_kind_e kind_w;
  logic      wide_w;

  lth_session #(.NREG(NREG), .AW(AW), .WIDE_MASK(WIDE_MASK)) u_sess (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_n_i       (acc_n_i),
    .hit_i         (hit_i),
    .cap_hit_i     (cap_hit_i),
    .rom_hit_i     (rom_hit_i),
    .cmd_i         (cmd_i),
    .addr_i        (addr_i),
    .open_o        (open_w),
    .kind_o        (kind_w),
    .wide_o        (wide_w),
    .loc_acc_n_o   (loc_acc_n_o),
    .loc_hit_o     (loc_hit_o),
    .loc_cap_hit_o (loc_cap_hit_o),
    .loc_rom_hit_o (loc_rom_hit_o),
    .loc_cmd_o     (loc_cmd_o),
    .loc_addr_o    (loc_addr_o),
    .loc_rd_nwr_o  (loc_rd_nwr_o)
  );

  lth_xfer #(.DW(DW)) u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .open_i       (open_w),
    .kind_i       (kind_w),
    .wide_i       (wide_w),
    .acc_n_i      (acc_n_i),
    .bus_dv_i     (bus_dv_i),
    .wdata_i      (wdata_i),
    .wbe_i        (wbe_i),
    .loc_rdy_n_i  (loc_rdy_n_i),
    .loc_rdata_i  (loc_rdata_i),
    .bus_take_o   (bus_take_o),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .loc_wdata_o  (loc_wdata_o),
    .loc_be_o     (loc_be_o),
    .xfer_lo_n_o  (xfer_lo_n_o),
    .xfer_hi_n_o  (xfer_hi_n_o)
  );

  AST_XFER_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_lo_n_o || !xfer_hi_n_o) |-> !loc_acc_n_o); // R11

endmodule

// File: tb/sim_lth_target.sv
`timescale 1ns/1ps
module sim_lth_target;

  localparam int NREG = 6;
  localparam int AW   = 64;
  localparam int DW   = 64;
  localparam logic [31:0] WMASK = 32'b100100;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acc_n_i = 1'b1;
  logic [NREG-1:0] hit_i = '0;
  logic            cap_hit_i = 1'b0;
  logic            rom_hit_i = 1'b0;
  logic [3:0]      cmd_i = '0;
  logic [AW-1:0]   addr_i = '0;
  logic            bus_dv_i = 1'b0;
  logic [DW-1:0]   wdata_i = '0;
  logic [7:0]      wbe_i = 8'b1011_0110;
  logic            loc_rdy_n_i = 1'b1;
  logic [DW-1:0]   loc_rdata_i;
  logic            bus_take_o, bus_rvalid_o, loc_acc_n_o, loc_cap_hit_o, loc_rom_hit_o;
  logic            loc_rd_nwr_o, xfer_lo_n_o, xfer_hi_n_o;
  logic [DW-1:0]   bus_rdata_o, loc_wdata_o;
  logic [NREG-1:0] loc_hit_o;
  logic [3:0]      loc_cmd_o;
  logic [AW-1:0]   loc_addr_o;
  logic [7:0]      loc_be_o;

  lth_target #(.NREG(NREG), .AW(AW), .DW(DW), .WIDE_MASK(WMASK)) u0 (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int lptr = 0, nx = 0, nhi = 0, nw = 0, nr = 0, nacc = 0;
  int v_rdy = 0, v_acc = 0, v_hi = 0, first_x = -1, last_x = -1;
  bit take_seen = 0, xfer_seen = 0, prev_rdy_n = 1;
  logic [63:0] got_w [0:63];
  logic [7:0]  got_be[0:63];
  logic [63:0] got_r [0:63];

  function automatic logic [63:0] wword(input int k);
    return {32'h1000_0000 + 32'(k) * 32'h0101, 32'hF00D_0000 + 32'(k)};
  endfunction
  function automatic logic [63:0] rword(input int k);
    return {32'h2222_0000 + 32'(k), 32'hBEEF_0000 + 32'(k) * 3};
  endfunction

  assign loc_rdata_i = rword(lptr);

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_up();
    end
  end

  // Local model: the word on loc_rdata_i advances after each strobed cycle.
  always @(posedge clk) begin
    #1;
    if (xfer_seen) lptr++;
  end

  always @(negedge clk) begin
    take_seen = bus_take_o;
    xfer_seen = !xfer_lo_n_o;
    if (!xfer_lo_n_o) begin
      nx++;
      if (!xfer_hi_n_o) nhi++;
      if (prev_rdy_n) v_rdy++;
      if (loc_acc_n_o) v_acc++;
      if (!loc_rd_nwr_o) begin got_w[nw] = loc_wdata_o; got_be[nw] = loc_be_o; nw++; end
      if (first_x < 0) first_x = cyc;
      last_x = cyc;
    end
    if (!xfer_hi_n_o && xfer_lo_n_o) v_hi++;
    if (!xfer_hi_n_o && loc_acc_n_o) v_acc++;
    if (bus_rvalid_o) begin got_r[nr] = bus_rdata_o; nr++; end
    if (!loc_acc_n_o) nacc++;
    prev_rdy_n = loc_rdy_n_i;
  end

  // One access: n words, local wait every 'we' cycles (0 = none).
  task automatic do_access(input logic [3:0] cmd, input logic [NREG-1:0] hits,
                           input bit cap, input bit rom, input int n, input int we,
                           input bit rsvd, input bit special, input bit wide, input bit rd);
    int bptr = 0, cc = 0;
    logic [7:0] exp_hits;
    logic [63:0] e;
    nx = 0; nhi = 0; nw = 0; nr = 0; nacc = 0; v_rdy = 0; v_acc = 0; v_hi = 0;
    first_x = -1; last_x = -1; lptr = 0;
    exp_hits = special ? 8'h00 : {rom, cap, hits};
    @(posedge clk); #1;
    acc_n_i = 1'b0; cmd_i = cmd; hit_i = hits; cap_hit_i = cap; rom_hit_i = rom;
    addr_i = {32'hCAFE_0000 + 32'(cmd), 32'h0000_1000 + 32'(n)};
    bus_dv_i = 1'b1; wdata_i = wword(0);
    loc_rdy_n_i = (we != 0) && (0 % we == we - 1);
    @(negedge clk);
    chk(loc_acc_n_o == 1'b1, "R2 latency", 64'(loc_acc_n_o), 64'd1);
    @(negedge clk);
    chk(loc_acc_n_o == rsvd, rsvd ? "R10 session hidden" : "R2 session open", 64'(loc_acc_n_o), 64'(rsvd));
    if (!rsvd) begin
      chk({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o} == exp_hits, special ? "R3 no hit" : "R2 hit",
          64'({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o}), 64'(exp_hits));
      chk(loc_cmd_o == cmd && loc_addr_o == {32'hCAFE_0000 + 32'(cmd), 32'h0000_1000 + 32'(n)},
          "R2 cmd/addr", loc_addr_o, {32'hCAFE_0000 + 32'(cmd), 32'h0000_1000 + 32'(n)});
    end
    for (int it = 0; it < 400 && bptr < n; it++) begin
      @(posedge clk); #1;
      if (take_seen) bptr++;
      cc++;
      loc_rdy_n_i = (we != 0) && (cc % we == we - 1);
      wdata_i = wword(bptr);
      if (bptr >= n) begin
        acc_n_i = 1'b1; bus_dv_i = 1'b0; hit_i = '0; cap_hit_i = 1'b0; rom_hit_i = 1'b0;
      end
    end
    @(negedge clk); @(negedge clk);
    chk(loc_acc_n_o == 1'b1, "R9 session closed", 64'(loc_acc_n_o), 64'd1);
    chk({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o} == '0, "R9 hits cleared",
        64'({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o}), 64'd0);
    repeat (3) @(negedge clk);
    loc_rdy_n_i = 1'b1;
    chk(v_acc == 0, "R11 strobe outside session", 64'(v_acc), 64'd0);
    chk(v_rdy == 0, "R4 strobe without ready", 64'(v_rdy), 64'd0);
    chk(v_hi == 0, "R8 high strobe alone", 64'(v_hi), 64'd0);
    if (rsvd) begin
      chk(nx == 0 && nacc == 0, "R10 no local activity", 64'(nx + nacc), 64'd0);
      chk(nr == n, "R10 reply count", 64'(nr), 64'(n));
      for (int k = 0; k < n && k < nr; k++)
        chk(got_r[k] == 64'd0, "R10 zero reply", got_r[k], 64'd0);
    end else begin
      chk(nx == n, rd ? "R4 strobe count" : "R6 strobe count", 64'(nx), 64'(n));
      chk(nhi == (wide ? n : 0), wide ? "R8 paired strobes" : "R7 no high strobe", 64'(nhi), 64'(wide ? n : 0));
      if (we == 0)
        chk(last_x - first_x + 1 == n, "R5 back-to-back burst", 64'(last_x - first_x + 1), 64'(n));
      else
        chk(last_x - first_x + 1 > n, "R5 waits inserted", 64'(last_x - first_x + 1), 64'(n + 1));
      if (rd) begin
        chk(nr == n, "R4 read count", 64'(nr), 64'(n));
        for (int k = 0; k < n && k < nr; k++) begin
          e = wide ? rword(k) : {32'd0, rword(k)[31:0]};
          chk(got_r[k] == e, wide ? "R4 read word" : "R7 read word", got_r[k], e);
        end
      end else begin
        chk(nw == n, "R6 write count", 64'(nw), 64'(n));
        for (int k = 0; k < n && k < nw; k++) begin
          e = wide ? wword(k) : {32'd0, wword(k)[31:0]};
          chk(got_w[k] == e, wide ? "R6 write word" : "R7 write word", got_w[k], e);
          chk(got_be[k] == (wide ? 8'b1011_0110 : 8'b0000_0110), "R7 byte enables",
              64'(got_be[k]), 64'(wide ? 8'b1011_0110 : 8'b0000_0110));
        end
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(loc_acc_n_o && xfer_lo_n_o && xfer_hi_n_o && !bus_rvalid_o, "R1 idle outputs",
        64'({loc_acc_n_o, xfer_lo_n_o, xfer_hi_n_o, bus_rvalid_o}), 64'b1110);
    chk({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o} == '0, "R1 hits clear",
        64'({loc_rom_hit_o, loc_cap_hit_o, loc_hit_o}), 64'd0);
  endtask

  task automatic t_wide_read();    do_access(4'b0110, 6'b000100, 0, 0, 6, 0, 0, 0, 1, 1); endtask
  task automatic t_narrow_read();  do_access(4'b0110, 6'b000001, 0, 0, 5, 3, 0, 0, 0, 1); endtask
  task automatic t_wide_write();   do_access(4'b0111, 6'b100000, 0, 0, 4, 2, 0, 0, 1, 0); endtask
  task automatic t_narrow_write(); do_access(4'b0111, 6'b000010, 0, 0, 4, 0, 0, 0, 0, 0); endtask
  task automatic t_special();      do_access(4'b0001, 6'b000100, 0, 0, 2, 0, 0, 1, 0, 0); endtask
  task automatic t_reserved();
    do_access(4'b0100, 6'b000001, 0, 0, 3, 0, 1, 0, 0, 1);
    do_access(4'b1001, 6'b000100, 0, 0, 2, 0, 1, 0, 0, 0);
  endtask
  task automatic t_cap_read();     do_access(4'b1010, 6'b000000, 1, 0, 2, 0, 0, 0, 0, 1); endtask

  initial begin
    t_reset();
    t_wide_read();
    t_narrow_read();
    t_wide_write();
    t_narrow_write();
    t_special();
    t_reserved();
    t_cap_read();
    repeat (2) @(posedge clk);
    finish_up();
  end

endmodule